// File: doc/BRIEF.md
# Partitioned throttle combiner

The block collects back-pressure (throttle) lines from many front-end and trigger sources and delivers one combined throttle to each of several readout masters. Each master runs its own detector partition. Software chooses, per source, which master the source belongs to and whether the source is ignored. Every source line passes through a two-stage synchroniser. Each master output is then the registered OR of the enabled sources assigned to that master.

So that the cause of a throttle can be traced later, the block logs every change of the enabled source lines into a circular history memory. Each entry holds a free-running timestamp and the complete synchronised source vector. Software can freeze logging and then walk the memory through an address register and two data windows. A status word reports the next write slot and whether the memory has wrapped.

Top module: `throttle_combiner`

## Requirements
- R1: After reset, every master output is 0. CTRL, MASK, HADDR, the route words and STATUS all read 0.
- R2: Master output m equals the OR of the synchronised inputs that are unmasked and routed to m. A change on `thr_in` reaches `mst_throttle` on the third rising clock edge after the change and not earlier.
- R3: An input whose MASK bit is 1 (register address 2, bit i for input i) never affects any master output and never creates a history entry.
- R4: The master of input i is the 2-bit field at bits [2(i mod 16)+1 : 2(i mod 16)] of route word i/16. Route word k is at address 8+k.
- R5: A history entry is written whenever any unmasked synchronised input changes. The entry holds the full 32-bit synchronised input vector and a 16-bit timestamp. The timestamp counter is 0 at reset and increments on every clock edge. The value stored is the counter value at the second rising edge after the input change.
- R6: While CTRL bit 0 (freeze) is 1, no history entry is written and the write pointer does not move. Input changes made during a freeze are not logged after the freeze is released.
- R7: The write pointer advances by one for each entry and wraps from 255 to 0. STATUS (address 1) carries the write pointer in bits [15:8] and a wrap flag in bit 0. The flag becomes 1 at the first wrap and stays 1 until reset.
- R8: HADDR (address 3) selects a history slot with its low 8 bits. A read of address 4 returns the slot's timestamp in bits [15:0], with the upper bits 0. A read of address 5 returns the slot's input vector.
- R9: Writes take effect at the clock edge where `cfg_we` is 1. `cfg_rdata` shows, one edge later, the register addressed by `cfg_addr`. CTRL is address 0, bit 0. MASK, HADDR and the route words read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_in | input | 32 | Asynchronous throttle inputs from the sources |
| mst_throttle | output | 4 | Combined throttle, one bit per master |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |

## Verification
The bench samples the output on the second and the third edge after an input change, which exposes a synchroniser with one stage too few or too many. It routes a single input to master 2 with every other input masked, which catches a swapped route field or a route word decoded at the wrong address. It changes only masked inputs, and then toggles inputs during a freeze and releases it. A design that let masked bits reach the OR, or that compared against a stale vector after a freeze, would show a spurious output or a moved write pointer. It also drives more than 256 logged changes and reads back timestamps and vectors around the pointer, which catches an off-by-one timestamp, a pointer that fails to wrap, or a wrap flag that never sets.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [CFG_AW-1:0] A_STAT   = 4'd1;
  localparam logic [CFG_AW-1:0] A_MASK   = 4'd2;
  localparam logic [CFG_AW-1:0] A_HADDR  = 4'd3;
  localparam logic [CFG_AW-1:0] A_HTS    = 4'd4;
  localparam logic [CFG_AW-1:0] A_HVEC   = 4'd5;
  localparam logic [CFG_AW-1:0] A_ROUTE0 = 4'd8;

  localparam int STAT_PTR_LSB = 8;

  // number of configuration words needed to hold all route fields
  function automatic int route_words(int n_in, int sel_w);
    return (n_in * sel_w + CFG_DW - 1) / CFG_DW;
  endfunction
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/thr_route.sv
module thr_route #(
  parameter int N_IN  = 32,
  parameter int N_MST = 4,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       sync_vec,
  input  logic [N_IN-1:0]       mask,
  input  logic [N_IN*SEL_W-1:0] route_vec,
  output logic [N_MST-1:0]      mst_out
);
  logic [N_IN-1:0] enabled;
  assign enabled = sync_vec & ~mask;

  // membership of every input in the partition of master m
  function automatic logic [N_IN-1:0] members(input logic [N_IN*SEL_W-1:0] rv,
                                              input logic [SEL_W-1:0] m);
    logic [N_IN-1:0] r;
    for (int i = 0; i < N_IN; i++) r[i] = (rv[i*SEL_W +: SEL_W] == m);
    return r;
  endfunction

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic [N_IN-1:0] active;
    assign active = enabled & members(route_vec, SEL_W'(m));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mst_out[m] <= 1'b0;
      else        mst_out[m] <= |active;
    end
  end
endmodule

// File: rtl/thr_history.sv
module thr_history #(
  parameter int N_IN  = 32,
  parameter int TS_W  = 16,
  parameter int DEPTH = 256,
  parameter int HP_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] sync_vec,
  input  logic [N_IN-1:0] mask,
  input  logic            freeze,
  input  logic [HP_W-1:0] rd_addr,
  output logic [TS_W-1:0] rd_ts,
  output logic [N_IN-1:0] rd_vec,
  output logic            hist_we,
  output logic [HP_W-1:0] wptr,
  output logic            wrapped
);
  localparam int EW = TS_W + N_IN;

  logic [N_IN-1:0] prev_vec;
  logic [TS_W-1:0] ts;
  logic [EW-1:0]   mem [DEPTH];
  logic            change;

  assign change  = |((sync_vec ^ prev_vec) & ~mask);
  assign hist_we = change && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vec <= '0;
      ts       <= '0;
      wptr     <= '0;
      wrapped  <= 1'b0;
    end else begin
      prev_vec <= sync_vec;
      ts       <= ts + TS_W'(1);
      if (hist_we) begin
        wptr <= wptr + HP_W'(1);
        if (wptr == HP_W'(DEPTH - 1)) wrapped <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hist_we) mem[wptr] <= {ts, sync_vec};
  end

  assign {rd_ts, rd_vec} = mem[rd_addr];
endmodule

// File: rtl/throttle_combiner.sv
module throttle_combiner
  import throttle_pkg::*;
#(
  parameter int N_IN       = 32,
  parameter int N_MST      = 4,
  parameter int TS_W       = 16,
  parameter int HIST_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   thr_in,
  output logic [N_MST-1:0]  mst_throttle,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata
);
  localparam int SEL_W = $clog2(N_MST);
  localparam int HP_W  = $clog2(HIST_DEPTH);
  localparam int RW    = route_words(N_IN, SEL_W);

  logic [N_IN-1:0]     sync_vec;
  logic [N_IN-1:0]     mask_q;
  logic                ctrl_freeze;
  logic [HP_W-1:0]     haddr_q;
  logic [RW*CFG_DW-1:0] route_q;
  logic [TS_W-1:0]     h_ts;
  logic [N_IN-1:0]     h_vec;
  logic                hist_we;
  logic [HP_W-1:0]     hist_wptr;
  logic                hist_wrapped;
  logic [CFG_DW-1:0]   rd_next;

  thr_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(thr_in), .q(sync_vec)
  );

  thr_route #(.N_IN(N_IN), .N_MST(N_MST), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .sync_vec(sync_vec), .mask(mask_q),
    .route_vec(route_q[N_IN*SEL_W-1:0]), .mst_out(mst_throttle)
  );

  thr_history #(.N_IN(N_IN), .TS_W(TS_W), .DEPTH(HIST_DEPTH), .HP_W(HP_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .sync_vec(sync_vec), .mask(mask_q),
    .freeze(ctrl_freeze), .rd_addr(haddr_q), .rd_ts(h_ts), .rd_vec(h_vec),
    .hist_we(hist_we), .wptr(hist_wptr), .wrapped(hist_wrapped)
  );

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      ctrl_freeze <= 1'b0;
      haddr_q     <= '0;
      route_q     <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_CTRL)  ctrl_freeze <= cfg_wdata[0];
      if (cfg_addr == A_MASK)  mask_q      <= cfg_wdata[N_IN-1:0];
      if (cfg_addr == A_HADDR) haddr_q     <= cfg_wdata[HP_W-1:0];
      for (int k = 0; k < RW; k++)
        if (cfg_addr == A_ROUTE0 + CFG_AW'(k)) route_q[k*CFG_DW +: CFG_DW] <= cfg_wdata;
    end
  end

  // read multiplexer
  always_comb begin
    rd_next = '0;
    case (cfg_addr)
      A_CTRL:  rd_next[0] = ctrl_freeze;
      A_STAT: begin
        rd_next[0] = hist_wrapped;
        rd_next[STAT_PTR_LSB +: HP_W] = hist_wptr;
      end
      A_MASK:  rd_next[N_IN-1:0] = mask_q;
      A_HADDR: rd_next[HP_W-1:0] = haddr_q;
      A_HTS:   rd_next[TS_W-1:0] = h_ts;
      A_HVEC:  rd_next[N_IN-1:0] = h_vec;
      default: begin
        for (int k = 0; k < RW; k++)
          if (cfg_addr == A_ROUTE0 + CFG_AW'(k)) rd_next = route_q[k*CFG_DW +: CFG_DW];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rdata <= '0;
    else        cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/throttle_combiner_chk.sv
module throttle_combiner_chk #(
  parameter int N_IN  = 32,
  parameter int N_MST = 4,
  parameter int HP_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  sync_vec,
  input logic [N_IN-1:0]  mask_q,
  input logic [N_MST-1:0] mst_out,
  input logic             freeze,
  input logic             hist_we,
  input logic [HP_W-1:0]  wptr,
  input logic             wrapped
);
  // R2: a raised master output needs an enabled source one cycle earlier
  p_out_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|mst_out) |-> $past(|(sync_vec & ~mask_q)));

  // R3: with every input masked, all outputs drop on the next edge
  p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> (mst_out == '0));

  // R6: a frozen buffer keeps its write pointer
  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(wptr));

  // R7: pointer steps by one per entry and holds otherwise
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |=> (wptr == $past(wptr) + HP_W'(1)));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_we |=> $stable(wptr));

  // R7: wrap flag is sticky and rises only from the last slot
  p_wrap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);
  p_wrap_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> ($past(wptr) == {HP_W{1'b1}}));
endmodule

bind throttle_combiner throttle_combiner_chk #(.N_IN(N_IN), .N_MST(N_MST), .HP_W(HP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_vec(sync_vec), .mask_q(mask_q),
  .mst_out(mst_throttle), .freeze(ctrl_freeze), .hist_we(hist_we),
  .wptr(hist_wptr), .wrapped(hist_wrapped)
);

// File: tb/throttle_combiner_bench.sv
module throttle_combiner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] thr_in = '0;
  logic [3:0]  mst_throttle;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] cyc = '0;

  // reference state
  logic [31:0] m_mask = '0;
  logic [63:0] m_route = '0;
  logic        m_freeze = 1'b0;
  logic [31:0] m_cur = '0;
  logic [15:0] m_ts [256];
  logic [31:0] m_vec [256];
  logic [7:0]  m_wp = '0;
  int          m_cnt = 0;

  throttle_combiner u_throttle_combiner (
    .clk(clk), .rst_n(rst_n), .thr_in(thr_in), .mst_throttle(mst_throttle),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 16'd1;

  function automatic logic [3:0] exp_out(input logic [31:0] v, input logic [31:0] mk,
                                         input logic [63:0] rt);
    logic [3:0] o = '0;
    for (int i = 0; i < 32; i++)
      if (v[i] && !mk[i]) o[rt[2*i +: 2]] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] exp_status();
    return {16'd0, m_wp, 7'd0, (m_cnt >= 256)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 4'd0) m_freeze = d[0];
    if (a == 4'd2) m_mask = d;
    if (a == 4'd8) m_route[31:0] = d;
    if (a == 4'd9) m_route[63:32] = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // call just after a negedge: updates the model and drives the input
  task automatic drive_now(input logic [31:0] v);
    if ((((v ^ m_cur) & ~m_mask) != 0) && !m_freeze) begin
      m_ts[m_wp]  = cyc + 16'd2;
      m_vec[m_wp] = v;
      m_wp++;
      m_cnt++;
    end
    m_cur  = v;
    thr_in = v;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    drive_now(v);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_hist(input logic [7:0] slot);
    logic [31:0] d;
    wr(4'd3, {24'd0, slot});
    rd(4'd4, d); check("R5 R8 history timestamp", d, {16'd0, m_ts[slot]});
    rd(4'd5, d); check("R5 R8 history vector", d, m_vec[slot]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    logic [31:0] st;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 outputs after reset", {28'd0, mst_throttle}, 32'd0);
    rd(4'd1, d); check("R1 status after reset", d, 32'd0);
    rd(4'd2, d); check("R1 mask after reset", d, 32'd0);
    rd(4'd0, d); check("R1 ctrl after reset", d, 32'd0);
    rd(4'd8, d); check("R1 route word 0 after reset", d, 32'd0);

    // R2 latency: all inputs route to master 0 by default
    @(negedge clk);
    drive_now(32'h0000_0020);
    @(negedge clk);
    @(negedge clk);
    check("R2 no output at second edge", {28'd0, mst_throttle}, 32'd0);
    @(negedge clk);
    check("R2 output at third edge", {28'd0, mst_throttle}, 32'd1);
    repeat (2) @(negedge clk);
    check_hist(8'd0);

    // R4 directed: input 3 to master 2, all others masked
    wr(4'd8, 32'h0000_0080);
    wr(4'd9, 32'h0);
    wr(4'd2, ~32'h0000_0008);
    drive(32'hFFFF_FFFF);
    check("R4 single route to master 2", {28'd0, mst_throttle}, 32'h4);
    rd(4'd8, d); check("R9 route word 0 readback", d, 32'h0000_0080);

    // R3 masked inputs: change only masked bits
    rd(4'd1, st);
    drive(32'h0000_0008);
    check("R3 masked bits cleared, output kept", {28'd0, mst_throttle}, 32'h4);
    rd(4'd1, d); check("R3 no entry from masked change", d, st);
    wr(4'd2, 32'hFFFF_FFFF);
    drive(32'h5A5A_5A5A);
    check("R3 all masked gives zero", {28'd0, mst_throttle}, 32'h0);
    rd(4'd1, d); check("R3 status unchanged when masked", d, exp_status());

    // R2 R4 random routing and patterns
    for (int it = 0; it < 60; it++) begin
      if (it % 10 == 0) begin
        wr(4'd8, $urandom);
        wr(4'd9, $urandom);
        wr(4'd2, $urandom & $urandom);
      end
      v = (it % 7 == 3) ? 32'h0 : ($urandom & $urandom & $urandom);
      drive(v);
      check("R2 R4 random master outputs", {28'd0, mst_throttle},
            {28'd0, exp_out(m_cur, m_mask, m_route)});
    end
    rd(4'd2, d); check("R9 mask readback", d, m_mask);
    rd(4'd9, d); check("R9 route word 1 readback", d, m_route[63:32]);
    rd(4'd1, d); check("R7 status after random phase", d, exp_status());
    for (int k = 1; k <= 6; k++) check_hist(m_wp - 8'(k));

    // R6 freeze
    wr(4'd2, 32'h0);
    wr(4'd0, 32'h1);
    rd(4'd0, d); check("R9 ctrl readback", d, 32'h1);
    rd(4'd1, st);
    drive(32'h1234_5678);
    drive(32'h8765_4321);
    rd(4'd1, d); check("R6 pointer frozen", d, st);
    wr(4'd0, 32'h0);
    repeat (4) @(negedge clk);
    rd(4'd1, d); check("R6 no entry after release", d, st);
    check("R2 output during freeze path", {28'd0, mst_throttle},
          {28'd0, exp_out(m_cur, m_mask, m_route)});

    // R7 wrap
    for (int it = 0; it < 260; it++) drive(m_cur ^ (32'h1 << (it % 32)));
    rd(4'd1, d); check("R7 wrap flag and pointer", d, exp_status());
    check("R7 model wrapped", {31'd0, d[0]}, 32'd1);
    for (int k = 1; k <= 4; k++) check_hist(m_wp - 8'(k));
    check_hist(m_wp + 8'd1);

    finish_run();
  end
endmodule